// File: doc/BRIEF.md
# GPIO Edge-Triggered Event Requester

This block is an eight-pin general-purpose I/O port for a node that reports pin changes as messages. Software programs each pin's direction, a port-wide weak pull-up switch, a per-pin edge enable and a per-pin edge polarity through a small register port. Pins set as outputs drive the value held in an output data register. The topmost pin can only be an input.

Every pin input goes through a two-stage synchronizer. An edge is found by comparing the newest synchronized sample with the one before it. When an enabled input pin shows an edge of its selected polarity, the block raises one transmit-on-change request toward a message controller. The request stays high until the controller acknowledges it. Edges that arrive while a request is still waiting are folded into that request. A latch that clears when read records which pins took part.

While the device is asleep, a qualifying edge raises a wake output and holds the request back. The request then appears as soon as the sleep indication drops.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset every direction bit reads 1 (input), so `pin_oe` is 0. `pin_pu`, `tx_req` and `wake_o` are 0, and the cause latch (address 6) reads 0.
- R2: Register map: address 0 is direction, 1 is the pull-up switch (bit 0), 2 is edge enable, 3 is edge polarity, 4 is output data, 5 reads the synchronized pins and 6 reads the cause latch. A direction bit of 1 means input. `pin_oe[i]` is the inverse of direction bit i, and `pin_out` equals the output data register. Pin 7's direction bit always reads 1 and `pin_oe[7]` is never 1.
- R3: `pin_pu[i]` is 1 exactly when the pull-up switch is 1 and pin i is an input.
- R4: A polarity bit of 1 selects the rising edge and 0 selects the falling edge. An edge of the other direction raises no request.
- R5: An edge on a pin whose edge enable is 0, or on a pin configured as an output, raises no request.
- R6: A pin change driven before a clock edge makes `tx_req` read 1 after the third rising clock edge, and not after the second. Once high, `tx_req` stays high until a cycle with `tx_ack` high.
- R7: Qualifying edges that occur while a request is pending are merged into it, so one acknowledge clears it. A qualifying edge detected in the same cycle as the acknowledge leaves `tx_req` high as a new request.
- R8: While `sleep_i` is 1, `tx_req` is 0 and a qualifying edge sets `wake_o`. When `sleep_i` falls, `tx_req` is 1 in the same cycle and `wake_o` is 0.
- R9: The cause latch collects the pins whose edges raised or joined the request. Reading address 6 returns it and clears it. The clear does not remove the pending request.
- R10: A pin held at a level through reset, with its enable and polarity written in the first two cycles after reset, raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears the cause latch on address 6) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from the address |
| pin_in | input | 8 | Raw pin levels |
| pin_out | output | 8 | Output data to the pin drivers |
| pin_oe | output | 8 | Output enable per pin |
| pin_pu | output | 8 | Weak pull-up enable per pin |
| sleep_i | input | 1 | Device is in low-power sleep |
| wake_o | output | 1 | Wake-up request |
| tx_req | output | 1 | Transmit-on-change request |
| tx_ack | input | 1 | Controller acknowledge |

## Verification
The bench builds the block with its defaults: two synchronizer stages and only pin 7 fixed as an input. With two stages, the request latency is exactly three clock edges, so the bench can place an acknowledge in the same cycle as a detected edge and check the merge-versus-new-request rule. With pin 7 fixed as an input, the bench can confirm that a write of all zeros to the direction register still leaves that pin an input with its pull-up live.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    localparam int GP_PINS   = 8;
    localparam int GP_ADDR_W = 3;

    typedef logic [GP_PINS-1:0] pin_vec_t;

    typedef enum logic [GP_ADDR_W-1:0] {
        A_DIR      = 3'd0,
        A_PULL     = 3'd1,
        A_EDGE_EN  = 3'd2,
        A_EDGE_POL = 3'd3,
        A_DOUT     = 3'd4,
        A_PIN      = 3'd5,
        A_CAUSE    = 3'd6
    } reg_addr_e;

    typedef struct packed {
        pin_vec_t dir;      // 1 = input
        pin_vec_t en;       // edge detect enable
        pin_vec_t pol;      // 1 = rising, 0 = falling
        pin_vec_t dout;     // output data
        logic     pull_on;  // port-wide pull-up switch
    } port_cfg_t;

    // Pins showing an edge of their selected polarity, gated by enable and input direction
    function automatic pin_vec_t edge_hits(pin_vec_t cur, pin_vec_t prev,
                                           pin_vec_t en, pin_vec_t dir, pin_vec_t pol);
        pin_vec_t rise;
        pin_vec_t fall;
        rise = cur & ~prev;
        fall = ~cur & prev;
        return en & dir & ((pol & rise) | (~pol & fall));
    endfunction

endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_edge_pkg::*;
#(
    parameter pin_vec_t INPUT_ONLY_MASK = {1'b1, {(GP_PINS-1){1'b0}}}
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr,
    input  logic [GP_ADDR_W-1:0] addr,
    input  pin_vec_t             wdata,
    output port_cfg_t            cfg
);

    port_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.dir     <= '1;
            cfg_q.en      <= '0;
            cfg_q.pol     <= '0;
            cfg_q.dout    <= '0;
            cfg_q.pull_on <= 1'b0;
        end else if (wr) begin
            case (reg_addr_e'(addr))
                A_DIR:      cfg_q.dir     <= wdata | INPUT_ONLY_MASK;
                A_PULL:     cfg_q.pull_on <= wdata[0];
                A_EDGE_EN:  cfg_q.en      <= wdata;
                A_EDGE_POL: cfg_q.pol     <= wdata;
                A_DOUT:     cfg_q.dout    <= wdata;
                default:    ;
            endcase
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync
    import gpio_edge_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  pin_vec_t raw,
    output pin_vec_t cur,
    output pin_vec_t prev,
    output logic     primed
);

    localparam int PRIME_CYC = SYNC_STAGES + 1;
    localparam int CNT_W     = $clog2(PRIME_CYC + 1);

    pin_vec_t           stage_q [SYNC_STAGES];
    pin_vec_t           prev_q;
    logic [CNT_W-1:0]   cnt_q;

    generate
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= raw;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            cnt_q  <= '0;
        end else begin
            prev_q <= stage_q[SYNC_STAGES-1];
            if (cnt_q != CNT_W'(PRIME_CYC)) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cur    = stage_q[SYNC_STAGES-1];
    assign prev   = prev_q;
    assign primed = (cnt_q == CNT_W'(PRIME_CYC));

endmodule

// File: rtl/gpio_req_ctrl.sv
module gpio_req_ctrl
    import gpio_edge_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pin_vec_t hits,
    input  logic     sleep_i,
    input  logic     ack,
    input  logic     cause_clr,
    output logic     tx_req,
    output logic     wake_o,
    output pin_vec_t cause
);

    logic     pending_q;
    pin_vec_t cause_q;
    logic     any_hit;
    logic     served;

    assign any_hit = |hits;
    assign served  = ack & tx_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q <= 1'b0;
            cause_q   <= '0;
        end else begin
            pending_q <= any_hit | (pending_q & ~served);
            cause_q   <= (cause_clr ? '0 : cause_q) | hits;
        end
    end

    assign tx_req = pending_q & ~sleep_i;
    assign wake_o = pending_q & sleep_i;
    assign cause  = cause_q;

endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
    import gpio_edge_pkg::*;
#(
    parameter int       SYNC_STAGES     = 2,
    parameter pin_vec_t INPUT_ONLY_MASK = {1'b1, {(GP_PINS-1){1'b0}}}
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [GP_ADDR_W-1:0] reg_addr,
    input  logic [GP_PINS-1:0]   reg_wdata,
    output logic [GP_PINS-1:0]   reg_rdata,
    input  logic [GP_PINS-1:0]   pin_in,
    output logic [GP_PINS-1:0]   pin_out,
    output logic [GP_PINS-1:0]   pin_oe,
    output logic [GP_PINS-1:0]   pin_pu,
    input  logic                 sleep_i,
    output logic                 wake_o,
    output logic                 tx_req,
    input  logic                 tx_ack
);

    port_cfg_t cfg;
    pin_vec_t  sync_cur;
    pin_vec_t  sync_prev;
    logic      sync_primed;
    pin_vec_t  hits;
    pin_vec_t  cause;
    logic      cause_clr;

    gpio_cfg_regs #(
        .INPUT_ONLY_MASK(INPUT_ONLY_MASK)
    ) u_regs (
        .clk  (clk),
        .rst  (rst),
        .wr   (reg_wr),
        .addr (reg_addr),
        .wdata(reg_wdata),
        .cfg  (cfg)
    );

    gpio_pin_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst   (rst),
        .raw   (pin_in),
        .cur   (sync_cur),
        .prev  (sync_prev),
        .primed(sync_primed)
    );

    assign hits = sync_primed ? edge_hits(sync_cur, sync_prev, cfg.en, cfg.dir, cfg.pol) : '0;
    assign cause_clr = reg_rd && (reg_addr == A_CAUSE);

    gpio_req_ctrl u_req (
        .clk      (clk),
        .rst      (rst),
        .hits     (hits),
        .sleep_i  (sleep_i),
        .ack      (tx_ack),
        .cause_clr(cause_clr),
        .tx_req   (tx_req),
        .wake_o   (wake_o),
        .cause    (cause)
    );

    assign pin_out = cfg.dout;
    assign pin_oe  = ~cfg.dir;
    assign pin_pu  = cfg.pull_on ? cfg.dir : '0;

    always_comb begin
        case (reg_addr_e'(reg_addr))
            A_DIR:      reg_rdata = cfg.dir;
            A_PULL:     reg_rdata = {{(GP_PINS-1){1'b0}}, cfg.pull_on};
            A_EDGE_EN:  reg_rdata = cfg.en;
            A_EDGE_POL: reg_rdata = cfg.pol;
            A_DOUT:     reg_rdata = cfg.dout;
            A_PIN:      reg_rdata = sync_cur;
            A_CAUSE:    reg_rdata = cause;
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_edge_port_chk.sv
module gpio_edge_port_chk
    import gpio_edge_pkg::*;
#(
    parameter pin_vec_t INPUT_ONLY_MASK = {1'b1, {(GP_PINS-1){1'b0}}}
) (
    input logic         clk,
    input logic         rst,
    input logic [GP_PINS-1:0] pin_oe,
    input logic [GP_PINS-1:0] pin_pu,
    input logic         sleep_i,
    input logic         wake_o,
    input logic         tx_req,
    input logic         tx_ack
);

    // R1: outputs quiet in the cycle after reset
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (pin_oe == '0 && pin_pu == '0 && !tx_req && !wake_o));

    // R2: input-only pins never drive
    assert_input_only_R2: assert property (@(posedge clk) disable iff (rst)
        (pin_oe & INPUT_ONLY_MASK) == '0);

    // R3: no pull-up on a driven pin
    assert_pull_off_output_R3: assert property (@(posedge clk) disable iff (rst)
        (pin_pu & pin_oe) == '0);

    // R6: request held until acknowledged
    assert_req_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (tx_req && !tx_ack && !sleep_i) |=> (tx_req || sleep_i));

    // R8: no request while asleep
    assert_no_req_sleep_R8: assert property (@(posedge clk) disable iff (rst)
        sleep_i |-> !tx_req);

    // R8: wake only while asleep
    assert_wake_in_sleep_R8: assert property (@(posedge clk) disable iff (rst)
        wake_o |-> sleep_i);

    // R8: leaving sleep with a wake pending shows the request
    assert_wake_to_req_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(wake_o) && !sleep_i) |-> tx_req);

endmodule

bind gpio_edge_port gpio_edge_port_chk #(
    .INPUT_ONLY_MASK(INPUT_ONLY_MASK)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .pin_oe (pin_oe),
    .pin_pu (pin_pu),
    .sleep_i(sleep_i),
    .wake_o (wake_o),
    .tx_req (tx_req),
    .tx_ack (tx_ack)
);

// File: tb/gpio_edge_port_bench.sv
module gpio_edge_port_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;
    logic [7:0] pin_pu;
    logic       sleep_i = 1'b0;
    logic       wake_o;
    logic       tx_req;
    logic       tx_ack = 1'b0;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    gpio_edge_port u_gpio_edge_port (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu),
        .sleep_i(sleep_i), .wake_o(wake_o), .tx_req(tx_req), .tx_ack(tx_ack)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic eq(input string tag, input logic [7:0] act, input logic [7:0] exp);
        chk(act === exp, tag, act, exp);
    endtask

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        reg_addr = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        step();
        reg_rd = 1'b0;
    endtask

    task automatic ack();
        tx_ack = 1'b1;
        step();
        tx_ack = 1'b0;
    endtask

    task automatic do_reset(input logic [7:0] pins);
        rst = 1'b1;
        pin_in = pins;
        step(3);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        eq("R1 oe", pin_oe, 8'h00);
        eq("R1 pu", pin_pu, 8'h00);
        eq("R1 tx_req", {7'd0, tx_req}, 8'h00);
        eq("R1 wake", {7'd0, wake_o}, 8'h00);
        rd(3'd0, v); eq("R1 dir", v, 8'hFF);
        rd(3'd6, v); eq("R1 cause", v, 8'h00);
    endtask

    task automatic t_direction();
        logic [7:0] v;
        wr(3'd0, 8'h00);
        rd(3'd0, v); eq("R2 dir pin7 stays input", v, 8'h80);
        eq("R2 oe", pin_oe, 8'h7F);
        wr(3'd4, 8'h55);
        eq("R2 pin_out", pin_out, 8'h55);
        wr(3'd0, 8'hFF);
        eq("R2 oe back", pin_oe, 8'h00);
    endtask

    task automatic t_pullup();
        wr(3'd0, 8'h0F);
        wr(3'd1, 8'h01);
        eq("R3 pu mixed", pin_pu, 8'h8F);
        wr(3'd0, 8'hFF);
        eq("R3 pu all", pin_pu, 8'hFF);
        wr(3'd1, 8'h00);
        eq("R3 pu off", pin_pu, 8'h00);
    endtask

    task automatic t_rising();
        logic [7:0] v;
        wr(3'd3, 8'h01);
        wr(3'd2, 8'h01);
        pin_in[0] = 1'b1;
        step(2); eq("R6 not yet", {7'd0, tx_req}, 8'h00);
        step();  eq("R6 req at edge 3", {7'd0, tx_req}, 8'h01);
        step(2); eq("R6 held", {7'd0, tx_req}, 8'h01);
        ack();   eq("R6 acked", {7'd0, tx_req}, 8'h00);
        pin_in[0] = 1'b0;
        step(5); eq("R4 falling ignored when rising", {7'd0, tx_req}, 8'h00);
        rd(3'd6, v); eq("R9 cause", v, 8'h01);
        rd(3'd6, v); eq("R9 cause cleared", v, 8'h00);
    endtask

    task automatic t_falling();
        wr(3'd3, 8'h00);
        wr(3'd2, 8'h02);
        pin_in[1] = 1'b1;
        step(5); eq("R4 rising ignored when falling", {7'd0, tx_req}, 8'h00);
        pin_in[1] = 1'b0;
        step(3); eq("R4 falling edge", {7'd0, tx_req}, 8'h01);
        ack();
    endtask

    task automatic t_gating();
        logic [7:0] v;
        rd(3'd6, v);
        wr(3'd3, 8'hFF);
        wr(3'd2, 8'h04);
        wr(3'd0, 8'hFB);
        pin_in[2] = 1'b1;
        step(5); eq("R5 output pin ignored", {7'd0, tx_req}, 8'h00);
        pin_in[3] = 1'b1;
        step(5); eq("R5 disabled pin ignored", {7'd0, tx_req}, 8'h00);
        wr(3'd0, 8'hFF);
        pin_in[2] = 1'b0; pin_in[3] = 1'b0;
        step(4);
        rd(3'd6, v); eq("R5 cause empty", v, 8'h00);
    endtask

    task automatic t_merge();
        logic [7:0] v;
        wr(3'd3, 8'h30);
        wr(3'd2, 8'h30);
        pin_in[4] = 1'b1;
        step(3); eq("R7 first req", {7'd0, tx_req}, 8'h01);
        pin_in[5] = 1'b1;
        step(4); eq("R7 still one req", {7'd0, tx_req}, 8'h01);
        rd(3'd6, v); eq("R9 merged cause", v, 8'h30);
        eq("R9 read keeps req", {7'd0, tx_req}, 8'h01);
        ack(); eq("R7 single ack clears", {7'd0, tx_req}, 8'h00);
        step(2); eq("R7 stays clear", {7'd0, tx_req}, 8'h00);
    endtask

    task automatic t_ack_collide();
        wr(3'd3, 8'h00);
        pin_in[4] = 1'b0;
        step(3); eq("R7 req before collide", {7'd0, tx_req}, 8'h01);
        pin_in[5] = 1'b0;
        step(2);
        ack(); eq("R7 edge in ack cycle starts new req", {7'd0, tx_req}, 8'h01);
        ack(); eq("R7 second ack clears", {7'd0, tx_req}, 8'h00);
    endtask

    task automatic t_sleep();
        wr(3'd3, 8'h40);
        wr(3'd2, 8'h40);
        sleep_i = 1'b1;
        step();
        eq("R8 no wake idle", {7'd0, wake_o}, 8'h00);
        pin_in[6] = 1'b1;
        step(3);
        eq("R8 wake", {7'd0, wake_o}, 8'h01);
        eq("R8 req held back", {7'd0, tx_req}, 8'h00);
        ack();
        eq("R8 ack in sleep ignored", {7'd0, wake_o}, 8'h01);
        sleep_i = 1'b0;
        #1;
        eq("R8 req on waking", {7'd0, tx_req}, 8'h01);
        eq("R8 wake drops", {7'd0, wake_o}, 8'h00);
        @(negedge clk);
        ack();
        eq("R8 acked", {7'd0, tx_req}, 8'h00);
    endtask

    task automatic t_prime();
        do_reset(8'h80);
        wr(3'd3, 8'h80);
        wr(3'd2, 8'h80);
        step(4); eq("R10 no false edge after reset", {7'd0, tx_req}, 8'h00);
        pin_in[7] = 1'b0;
        step(4);
        pin_in[7] = 1'b1;
        step(3); eq("R10 detection live", {7'd0, tx_req}, 8'h01);
        ack();
    endtask

    initial begin
        @(negedge clk);
        do_reset(8'h00);
        t_reset();
        t_direction();
        t_pullup();
        t_rising();
        t_falling();
        t_gating();
        t_merge();
        t_ack_collide();
        t_sleep();
        t_prime();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule